// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block watches the clock and data lines of an I2C bus without driving them and keeps a flag telling whether the bus is currently owned by a transfer. Both bus lines are brought into the system clock domain through a synchronizer chain. All edge and condition analysis then runs on those sampled copies. No flop in the design is clocked by a bus line, and the whole block runs on one free-running clock.

A START condition sets the busy flag and a STOP condition clears it. A separate clear input drops the flag at any time, whatever the bus is doing. Each detected condition also produces a strobe one system clock wide. A later sniffer stage can use these strobes to frame bytes. A repeated START inside a transfer gives a fresh start strobe and leaves the flag set.

Top module: `i2c_cond_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, `start_o`, `stop_o` and `busy_o` are 0 after that edge. The synchronizer contents are also set so that the bus reads as idle (both lines high).
- R2: A START is `sda_i` going from 1 to 0 while `scl_i` is 1 both before and after the change. For a change applied just before rising edge k, with k the 1st edge, `start_o` is 1 after edge number SYNC_STAGES+1. It stays 1 for exactly one cycle.
- R3: A STOP is `sda_i` going from 0 to 1 while `scl_i` is 1 both before and after the change. `stop_o` pulses with the same timing as `start_o` in R2.
- R4: A START sets `busy_o` at the same edge that raises `start_o`. A STOP clears `busy_o` at the same edge that raises `stop_o`. Without a strobe or a clear, `busy_o` keeps its value.
- R5: An `sda_i` change while `scl_i` is 0 gives no strobe and leaves `busy_o` unchanged.
- R6: An `sda_i` change in the same sample as an `scl_i` change gives no strobe and leaves `busy_o` unchanged. This applies whether `scl_i` rises or falls.
- R7: A START while `busy_o` is already 1 pulses `start_o`, and `busy_o` stays 1.
- R8: When `busy_clr` is 1 at a rising edge, `busy_o` is 0 after that edge. This holds even if a START is detected at the same edge, and in that case `start_o` still pulses.
- R9: A STOP while `busy_o` is 0 pulses `stop_o`, and `busy_o` stays 0.
- R10: `start_o` and `stop_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock in the block |
| rst | input | 1 | Synchronous active-high reset |
| busy_clr | input | 1 | Synchronous clear of the busy flag; takes priority over a START |
| scl_i | input | 1 | Raw bus clock line, asynchronous to `clk` |
| sda_i | input | 1 | Raw bus data line, asynchronous to `clk` |
| start_o | output | 1 | One-cycle strobe for a detected START |
| stop_o | output | 1 | One-cycle strobe for a detected STOP |
| busy_o | output | 1 | Bus-busy flag |

## Verification
The bench builds the block with its default SYNC_STAGES of 2, which puts the strobe after the third edge. The bench takes that latency from the same parameter.

With that configuration the bench walks through every pairing of a settled line state with a next line state, 16 transitions, and does this twice: once with the flag clear and once with it set. Each pairing is reached along a path that cannot itself form a condition. This covers every legal START and STOP, data changes with the clock low, and simultaneous changes of both lines. The bench checks the strobes cycle by cycle across a window around the expected edge. Separate cases exercise the clear input, including a clear landing on the same edge as a START.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int LINE_COUNT = 2;
  localparam int IDX_SCL    = 1;
  localparam int IDX_SDA    = 0;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_smp_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else if (STAGES == 1) chain <= d[b];
      else chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bus_smp_t cur,
  output logic     det_start,
  output logic     det_stop,
  output logic     start_o,
  output logic     stop_o
);
  bus_smp_t prev;
  logic     scl_steady;

  always_ff @(posedge clk) begin
    if (rst) prev <= '{scl: 1'b1, sda: 1'b1};
    else     prev <= cur;
  end

  assign scl_steady = prev.scl & cur.scl;
  assign det_start  = scl_steady & prev.sda & ~cur.sda;
  assign det_stop   = scl_steady & ~prev.sda & cur.sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= det_start;
      stop_o  <= det_stop;
    end
  end

  a_r10_no_both: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));
  a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  a_r3_stop_single: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);
  a_r5_scl_low_quiet: assert property (@(posedge clk) disable iff (rst)
    !cur.scl |=> !start_o && !stop_o);
endmodule

// File: rtl/i2c_busy_track.sv
module i2c_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic busy_clr,
  input  logic det_start,
  input  logic det_stop,
  input  logic start_o,
  input  logic stop_o,
  output logic busy_o
);
  always_ff @(posedge clk) begin
    if (rst)            busy_o <= 1'b0;
    else if (busy_clr)  busy_o <= 1'b0;
    else if (det_start) busy_o <= 1'b1;
    else if (det_stop)  busy_o <= 1'b0;
  end

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    $past(busy_clr) |-> !busy_o);
  a_r4_set_on_start: assert property (@(posedge clk) disable iff (rst)
    start_o && !$past(busy_clr) |-> busy_o);
  a_r4_clear_on_stop: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> !busy_o);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !start_o && !stop_o && !$past(busy_clr) && !$past(rst) |-> busy_o == $past(busy_o));
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_clr,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  logic [LINE_COUNT-1:0] raw_lines;
  logic [LINE_COUNT-1:0] syn_lines;
  bus_smp_t              cur;
  logic                  det_start;
  logic                  det_stop;

  always_comb begin
    raw_lines          = '0;
    raw_lines[IDX_SCL] = scl_i;
    raw_lines[IDX_SDA] = sda_i;
  end

  i2c_line_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_lines),
    .q   (syn_lines)
  );

  assign cur.scl = syn_lines[IDX_SCL];
  assign cur.sda = syn_lines[IDX_SDA];

  i2c_cond_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .cur       (cur),
    .det_start (det_start),
    .det_stop  (det_stop),
    .start_o   (start_o),
    .stop_o    (stop_o)
  );

  i2c_busy_track u_busy (
    .clk       (clk),
    .rst       (rst),
    .busy_clr  (busy_clr),
    .det_start (det_start),
    .det_stop  (det_stop),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .busy_o    (busy_o)
  );
endmodule

// File: tb/sim_i2c_cond_monitor.sv
module sim_i2c_cond_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;
  localparam int LAT        = STAGES + 1;
  localparam int WIN        = LAT + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_clr = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic start_o, stop_o, busy_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_monitor #(.SYNC_STAGES(STAGES)) u0 (
    .clk(clk), .rst(rst), .busy_clr(busy_clr),
    .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_o), .stop_o(stop_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic settle();
    for (int i = 0; i < LAT + 3; i++) @(negedge clk);
  endtask

  // Move the lines to (s, d) without forming a condition: lower SCL first.
  task automatic go_state(input logic s, input logic d);
    @(negedge clk); scl_i = 1'b0; settle();
    @(negedge clk); sda_i = d;    settle();
    @(negedge clk); scl_i = s;    settle();
  endtask

  task automatic make_busy();
    go_state(1'b1, 1'b1);
    @(negedge clk); sda_i = 1'b0; settle();
  endtask

  task automatic do_clear();
    @(negedge clk); busy_clr = 1'b1;
    @(negedge clk); busy_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic exp_st, exp_sp, exp_busy;
    repeat (4) @(negedge clk);
    check("R1 start", start_o, 1'b0);
    check("R1 stop",  stop_o,  1'b0);
    check("R1 busy",  busy_o,  1'b0);
    rst = 1'b0;
    settle();
    check("R1 idle after release", busy_o, 1'b0);

    // Sweep: every from-state a, to-state b, with flag clear and set.
    for (int init = 0; init < 2; init++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          logic as, ad, bs, bd;
          as = a[1]; ad = a[0]; bs = b[1]; bd = b[0];
          do_clear();
          if (init == 1) make_busy();
          go_state(as, ad);
          check("R4 flag before step", busy_o, init[0]);
          exp_st = as & bs & ad & ~bd;
          exp_sp = as & bs & ~ad & bd;
          @(negedge clk); scl_i = bs; sda_i = bd;
          for (int j = 1; j <= WIN; j++) begin
            @(negedge clk);
            if (j == LAT) begin
              // R2 R3 R5 R6 timing at the expected edge
              check(exp_st ? "R2 start strobe" : "R5/R6 no start", start_o, exp_st);
              check(exp_sp ? "R3 stop strobe"  : "R5/R6 no stop",  stop_o,  exp_sp);
            end else begin
              check("R2 start width", start_o, 1'b0);
              check("R3 stop width",  stop_o,  1'b0);
            end
            check("R10 exclusive", start_o & stop_o, 1'b0);
          end
          exp_busy = exp_st ? 1'b1 : (exp_sp ? 1'b0 : init[0]);
          if (exp_st && init == 1) check("R7 repeated start keeps busy", busy_o, exp_busy);
          else if (exp_sp && init == 0) check("R9 stop while idle", busy_o, exp_busy);
          else check("R4 flag after step", busy_o, exp_busy);
        end
      end
    end

    // R8: clear while bus busy and idle lines.
    do_clear();
    make_busy();
    check("R8 setup busy", busy_o, 1'b1);
    do_clear();
    check("R8 clear during transfer", busy_o, 1'b0);

    // R8: clear on the same edge as the START strobe.
    go_state(1'b1, 1'b1);
    @(negedge clk); sda_i = 1'b0;
    for (int j = 1; j < LAT; j++) @(negedge clk);
    busy_clr = 1'b1;
    @(negedge clk);
    check("R8 start strobe still pulses", start_o, 1'b1);
    check("R8 clear beats start", busy_o, 1'b0);
    busy_clr = 1'b0;
    settle();
    check("R8 stays clear", busy_o, 1'b0);

    // R1: reset mid-transfer.
    make_busy();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears busy", busy_o, 1'b0);
    rst = 1'b0;
    settle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule